// File: doc/BRIEF.md
# Multi-Port Pin Controller with Edge Interrupts

This block controls a bank of general-purpose pins. Pins are grouped into identical ports of eight, up to seven ports, and each port owns its own window in the register space. Each pin has a drive mode, an output data bit, a pull-up control and a sampled input value. It also has an edge-detecting interrupt source with a selectable polarity and its own enable. Every port combines its enabled pending events into one registered interrupt line.

Software reaches the block through a simple synchronous bus. A write completes in the cycle it is presented. Read data appears on `bus_rdata` one cycle after the request. The pads themselves are outside the block. The controller only produces an output-enable, an output value and a pull-up-enable for each pin. An external pad model resolves these signals and returns the level it sees on `pad_in`. Both-edge interrupt operation is possible: software flips a pin's polarity bit after each event.

Top module: `gpio_bank`

## Requirements
- R1: Port n's window starts at byte address n*0x30. Within a window, 0x08 holds output data, 0x0C pin modes, 0x10 pull-up disables, 0x18 interrupt enables and 0x20 edge polarities, and each of these reads back what was written. A write changes only the addressed port.
- R2: The pin mode field for pin k sits at bits [2k+1:2k] of offset 0x0C. Code 00 is input and never drives. Code 01 is push-pull and always drives. Code 10 is open-drain and drives only while the data bit is 0. Code 11 is open-source and drives only while the data bit is 1. `pad_out` always carries the data bit.
- R3: A 1 in bit k of the pull-up disable register (offset 0x10) turns off `pad_pu` for pin k. A 0 leaves it on.
- R4: With synchronization enabled, offset 0x04 returns `pad_in` through a two-flop synchronizer. A pad change presented together with a read request is not yet seen by that read.
- R5: Bit k of the polarity register (offset 0x20) selects the edge. A 1 selects a rising edge and a 0 a falling edge. A matching edge sets bit k of the event register (offset 0x14), and the opposite edge leaves it unchanged.
- R6: Writing a 1 to bit k of offset 0x1C sets event bit k. Bits written as 0 have no effect.
- R7: Writing a 1 to an event bit clears it. When an edge and the clear land in the same cycle, the bit stays set.
- R8: `irq[n]` is the OR over port n's pins of event AND enable, taken through one register. It rises the cycle after the event bit is set.
- R9: The control register sits at address 0x00 and resets to 0x2. Bit 0 drives `clk_req`. Bit 1 selects the synchronized input. While bit 1 is 0, both reads and edge detection use `pad_in` directly, so a read issued together with a pad change already returns the new level.
- R10: The read-only identification register at address 0x2C returns the version in bits [8:2] and the port count in bits [15:9]. All other bits read 0.
- R11: After reset, all pins are inputs. Output data, interrupt enables, events and `irq` are 0, every `pad_pu` is 1, and `clk_req` is 0.
- R12: An address whose port index is at or beyond the configured port count reads 0 and ignores writes. So does an offset that has no register.
- R13: `bus_rdata` updates only in the cycle after a read request and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid one cycle after a read request |
| pad_in | input | NUM_PORTS*8 | Level seen at each pad |
| pad_oe | output | NUM_PORTS*8 | Pad driver enable per pin |
| pad_out | output | NUM_PORTS*8 | Pad drive value per pin |
| pad_pu | output | NUM_PORTS*8 | Pull-up enable per pin |
| irq | output | NUM_PORTS | Combined interrupt per port |
| clk_req | output | 1 | Clock request from control bit 0 |

## Verification
The bench sends a pad edge and a write-one clear into the same cycle. A design where the clear wins would lose that edge's event. It checks every drive mode against both data values, because swapping the open-drain and open-source cases, or the bit position of the mode field, shows up as a wrong enable on a specific pin. Reads are issued in the same cycle as a pad change, both with and without synchronization. A missing or extra synchronizer stage would return the wrong level. Other targets are the single-cycle interrupt latency, writes aimed past the last port, and a zero-valued force write. A design that aliased out-of-range ports onto real ones, or treated force bits as toggles, would fail them.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int PORT_PINS   = 8;
  localparam int PORT_STRIDE = 48;
  localparam int OFF_W       = 6;

  localparam logic [OFF_W-1:0] OFF_CTRL  = 6'h00;
  localparam logic [OFF_W-1:0] OFF_IN    = 6'h04;
  localparam logic [OFF_W-1:0] OFF_DOUT  = 6'h08;
  localparam logic [OFF_W-1:0] OFF_MODE  = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_PUD   = 6'h10;
  localparam logic [OFF_W-1:0] OFF_EVT   = 6'h14;
  localparam logic [OFF_W-1:0] OFF_EN    = 6'h18;
  localparam logic [OFF_W-1:0] OFF_FRC   = 6'h1C;
  localparam logic [OFF_W-1:0] OFF_EDGE  = 6'h20;
  localparam logic [OFF_W-1:0] OFF_IDENT = 6'h2C;

  typedef enum logic [1:0] {
    DRV_INPUT = 2'b00,
    DRV_PUSH  = 2'b01,
    DRV_SINK  = 2'b10,
    DRV_SRC   = 2'b11
  } drive_mode_e;

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stage_d[s] = d_in;
    end else begin : g_next
      assign stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d[s];
    end
  end

  assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int NUM_PORTS = 7,
  parameter int PIDX_W    = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [PIDX_W-1:0] port_idx,
  output logic [OFF_W-1:0]  offset,
  output logic              in_range
);

  localparam int SPAN = ((1 << ADDR_W) - 1) / PORT_STRIDE;

  int base_v;

  always_comb begin
    port_idx = '0;
    base_v   = 0;
    for (int k = 1; k <= SPAN; k++) begin
      if (int'(addr) >= k * PORT_STRIDE) begin
        port_idx = PIDX_W'(k);
        base_v   = k * PORT_STRIDE;
      end
    end
    offset   = OFF_W'(int'(addr) - base_v);
    in_range = (int'(port_idx) < NUM_PORTS);
  end

endmodule

// File: rtl/gpio_bank_port.sv
module gpio_bank_port
  import gpio_bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [OFF_W-1:0]       offset,
  input  logic [2*PORT_PINS-1:0] wdata,
  input  logic [PORT_PINS-1:0]   pin_val,
  output logic [DATA_W-1:0]      rd_val,
  output logic [PORT_PINS-1:0]   pad_oe,
  output logic [PORT_PINS-1:0]   pad_out,
  output logic [PORT_PINS-1:0]   pad_pu,
  output logic                   irq,
  output logic [2*PORT_PINS-1:0] mode_o,
  output logic [PORT_PINS-1:0]   dout_o,
  output logic [PORT_PINS-1:0]   en_o,
  output logic [PORT_PINS-1:0]   evt_o
);

  localparam int P = PORT_PINS;

  logic [2*P-1:0] mode_q, mode_d;
  logic [P-1:0]   dout_q, dout_d;
  logic [P-1:0]   pud_q,  pud_d;
  logic [P-1:0]   en_q,   en_d;
  logic [P-1:0]   edge_q, edge_d;
  logic [P-1:0]   evt_q,  evt_d;
  logic [P-1:0]   prev_q;
  logic           irq_q,  irq_d;

  logic [P-1:0] rise, fall, hit, frc_set, evt_clr;

  // edge detection and event update
  always_comb begin
    rise    = pin_val & ~prev_q;
    fall    = ~pin_val & prev_q;
    hit     = (rise & edge_q) | (fall & ~edge_q);
    frc_set = (wr_en && offset == OFF_FRC) ? wdata[P-1:0] : '0;
    evt_clr = (wr_en && offset == OFF_EVT) ? wdata[P-1:0] : '0;
    evt_d   = (evt_q & ~evt_clr) | hit | frc_set;
    irq_d   = |(evt_q & en_q);
  end

  // configuration registers
  always_comb begin
    mode_d = mode_q;
    dout_d = dout_q;
    pud_d  = pud_q;
    en_d   = en_q;
    edge_d = edge_q;
    if (wr_en) begin
      case (offset)
        OFF_MODE: mode_d = wdata;
        OFF_DOUT: dout_d = wdata[P-1:0];
        OFF_PUD:  pud_d  = wdata[P-1:0];
        OFF_EN:   en_d   = wdata[P-1:0];
        OFF_EDGE: edge_d = wdata[P-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dout_q <= '0;
      pud_q  <= '0;
      en_q   <= '0;
      edge_q <= '0;
      evt_q  <= '0;
      prev_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      dout_q <= dout_d;
      pud_q  <= pud_d;
      en_q   <= en_d;
      edge_q <= edge_d;
      evt_q  <= evt_d;
      prev_q <= pin_val;
      irq_q  <= irq_d;
    end
  end

  // per-pin driver enable from mode and data
  for (genvar i = 0; i < P; i++) begin : g_pin
    always_comb begin
      case (drive_mode_e'(mode_q[2*i +: 2]))
        DRV_INPUT: pad_oe[i] = 1'b0;
        DRV_PUSH:  pad_oe[i] = 1'b1;
        DRV_SINK:  pad_oe[i] = ~dout_q[i];
        DRV_SRC:   pad_oe[i] = dout_q[i];
        default:   pad_oe[i] = 1'b0;
      endcase
    end
  end

  assign pad_out = dout_q;
  assign pad_pu  = ~pud_q;
  assign irq     = irq_q;

  always_comb begin
    case (offset)
      OFF_IN:   rd_val = DATA_W'(pin_val);
      OFF_DOUT: rd_val = DATA_W'(dout_q);
      OFF_MODE: rd_val = DATA_W'(mode_q);
      OFF_PUD:  rd_val = DATA_W'(pud_q);
      OFF_EVT:  rd_val = DATA_W'(evt_q);
      OFF_EN:   rd_val = DATA_W'(en_q);
      OFF_EDGE: rd_val = DATA_W'(edge_q);
      default:  rd_val = '0;
    endcase
  end

  assign mode_o = mode_q;
  assign dout_o = dout_q;
  assign en_o   = en_q;
  assign evt_o  = evt_q;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS = 7,
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 32,
  parameter int VERSION   = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_sel,
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [DATA_W-1:0]              bus_rdata,
  input  logic [NUM_PORTS*PORT_PINS-1:0] pad_in,
  output logic [NUM_PORTS*PORT_PINS-1:0] pad_oe,
  output logic [NUM_PORTS*PORT_PINS-1:0] pad_out,
  output logic [NUM_PORTS*PORT_PINS-1:0] pad_pu,
  output logic [NUM_PORTS-1:0]           irq,
  output logic                           clk_req
);

  localparam int NPINS  = NUM_PORTS * PORT_PINS;
  localparam int SPAN   = ((1 << ADDR_W) - 1) / PORT_STRIDE;
  localparam int PIDX_W = $clog2(SPAN + 1);
  localparam logic [DATA_W-1:0] IDENT_VAL =
      DATA_W'((VERSION % 128) << 2) | DATA_W'(NUM_PORTS << 9);

  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  // address decode
  logic [PIDX_W-1:0] port_idx;
  logic [OFF_W-1:0]  offset;
  logic              in_range;

  gpio_bank_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_PORTS(NUM_PORTS),
    .PIDX_W   (PIDX_W)
  ) u_dec (
    .addr    (bus_addr),
    .port_idx(port_idx),
    .offset  (offset),
    .in_range(in_range)
  );

  logic wr_hit, rd_req, ctrl_wr;
  assign wr_hit  = bus_sel && bus_wr && in_range;
  assign rd_req  = bus_sel && !bus_wr;
  assign ctrl_wr = wr_hit && (port_idx == '0) && (offset == OFF_CTRL);

  // global control
  logic [1:0] ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = bus_wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) ctrl_q <= 2'b10;
    else         ctrl_q <= ctrl_d;
  end

  assign clk_req = ctrl_q[0];

  // input synchronization and source select
  logic [NPINS-1:0] pad_sync, pin_val;

  gpio_bank_sync #(
    .WIDTH (NPINS),
    .STAGES(2)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_sn),
    .d_in (pad_in),
    .d_out(pad_sync)
  );

  assign pin_val = ctrl_q[1] ? pad_sync : pad_in;

  // ports
  logic [DATA_W-1:0]      port_rd [NUM_PORTS];
  logic [2*NPINS-1:0]     mode_all;
  logic [NPINS-1:0]       dout_all, en_all, evt_all;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic port_wr;
    assign port_wr = wr_hit && (port_idx == PIDX_W'(p));

    gpio_bank_port #(
      .DATA_W(DATA_W)
    ) u_port (
      .clk    (clk),
      .rst_n  (rst_sn),
      .wr_en  (port_wr),
      .offset (offset),
      .wdata  (bus_wdata[2*PORT_PINS-1:0]),
      .pin_val(pin_val[p*PORT_PINS +: PORT_PINS]),
      .rd_val (port_rd[p]),
      .pad_oe (pad_oe[p*PORT_PINS +: PORT_PINS]),
      .pad_out(pad_out[p*PORT_PINS +: PORT_PINS]),
      .pad_pu (pad_pu[p*PORT_PINS +: PORT_PINS]),
      .irq    (irq[p]),
      .mode_o (mode_all[2*p*PORT_PINS +: 2*PORT_PINS]),
      .dout_o (dout_all[p*PORT_PINS +: PORT_PINS]),
      .en_o   (en_all[p*PORT_PINS +: PORT_PINS]),
      .evt_o  (evt_all[p*PORT_PINS +: PORT_PINS])
    );
  end

  // read path
  logic [DATA_W-1:0] rd_mux, rdata_q, rdata_d;

  always_comb begin
    rd_mux = '0;
    if (in_range) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (port_idx == PIDX_W'(p)) rd_mux = port_rd[p];
      end
      if (port_idx == '0 && offset == OFF_CTRL)  rd_mux = DATA_W'(ctrl_q);
      if (port_idx == '0 && offset == OFF_IDENT) rd_mux = IDENT_VAL;
    end
    rdata_d = rd_req ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:2*PORT_PINS];

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NUM_PORTS = 7,
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_sel,
  input logic                     bus_wr,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [DATA_W-1:0]        bus_wdata,
  input logic [DATA_W-1:0]        bus_rdata,
  input logic [NUM_PORTS*8-1:0]   pad_oe,
  input logic [NUM_PORTS*8-1:0]   pad_out,
  input logic [NUM_PORTS-1:0]     irq,
  input logic                     clk_req,
  input logic [NUM_PORTS*16-1:0]  mode_all,
  input logic [NUM_PORTS*8-1:0]   dout_all,
  input logic [NUM_PORTS*8-1:0]   en_all,
  input logic [NUM_PORTS*8-1:0]   evt_all
);

  localparam int NPINS = NUM_PORTS * 8;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    // R2: input mode never drives
    a_r2_input_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_all[2*i +: 2] == 2'b00) |-> !pad_oe[i]);
    // R2: open-drain drives only low
    a_r2_sink_low: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_all[2*i +: 2] == 2'b10 && pad_oe[i]) |-> !pad_out[i]);
    // R2: open-source drives only high
    a_r2_src_high: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_all[2*i +: 2] == 2'b11 && pad_oe[i]) |-> pad_out[i]);
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    // R8: no interrupt while the port has nothing enabled
    a_r8_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (en_all[8*p +: 8] == 8'h00) |=> !irq[p]);
  end

  // R6: force write sets the event bit
  a_r6_force_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == ADDR_W'(8'h1C) && bus_wdata[0]) |=> evt_all[0]);

  // R9: clock request only rises after a control write
  a_r9_clkreq_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_req) |-> $past(bus_sel && bus_wr && bus_addr == '0));

  // R12: writes beyond the last port change nothing
  a_r12_oob_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && int'(bus_addr) >= NUM_PORTS * 48)
      |=> ($stable(dout_all) && $stable(mode_all) && $stable(en_all)));

  // R13: read data holds without a read request
  a_r13_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata));

endmodule

bind gpio_bank gpio_bank_chk #(
  .NUM_PORTS(NUM_PORTS),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sn),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .pad_oe   (pad_oe),
  .pad_out  (pad_out),
  .irq      (irq),
  .clk_req  (clk_req),
  .mode_all (mode_all),
  .dout_all (dout_all),
  .en_all   (en_all),
  .evt_all  (evt_all)
);

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;

  localparam int NP    = 7;
  localparam int AW    = 9;
  localparam int DW    = 32;
  localparam int VER   = 3;
  localparam int NPINS = NP * 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bus_sel = 1'b0;
  logic             bus_wr = 1'b0;
  logic [AW-1:0]    bus_addr = '0;
  logic [DW-1:0]    bus_wdata = '0;
  logic [DW-1:0]    bus_rdata;
  logic [NPINS-1:0] pad_in = '0;
  logic [NPINS-1:0] pad_oe, pad_out, pad_pu;
  logic [NP-1:0]    irq;
  logic             clk_req;

  int total = 0;
  int bad   = 0;

  logic [DW-1:0] exp_q [$];
  string         tag_q [$];
  logic          rd_pend = 1'b0;
  logic          done = 1'b0;

  always #2 clk = ~clk;

  gpio_bank #(.NUM_PORTS(NP), .ADDR_W(AW), .DATA_W(DW), .VERSION(VER)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
    .irq(irq), .clk_req(clk_req)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare read results against the scoreboard queue
  always @(posedge clk) rd_pend <= bus_sel & ~bus_wr;

  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R13 unexpected read data actual=%0h expected=none", bus_rdata);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, 64'(bus_rdata), 64'(e));
      end
    end
  end

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // expected driver enables from R2
  function automatic logic [7:0] oe_model(input logic [15:0] m, input logic [7:0] d);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      case (m[2*i +: 2])
        2'b00: r[i] = 1'b0;
        2'b01: r[i] = 1'b1;
        2'b10: r[i] = ~d[i];
        default: r[i] = d[i];
      endcase
    end
    return r;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [NPINS-1:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk("R11 pad_oe", 64'(pad_oe), 64'(0));
    chk("R11 pad_pu", 64'(pad_pu), {8'h00, {NPINS{1'b1}}});
    chk("R11 irq", 64'(irq), 64'(0));
    chk("R11 clk_req", 64'(clk_req), 64'(0));
    bus_read(9'h000, 32'h2, "R11 R9 control reset");
    bus_read(9'h074, 32'h0, "R11 event reset");

    // R10 identification
    bus_read(9'h02C, 32'((VER << 2) | (NP << 9)), "R10 ident");

    // R1 window map and isolation
    bus_write(9'h038, 32'hA5);
    bus_read(9'h038, 32'hA5, "R1 port1 dout");
    bus_read(9'h008, 32'h00, "R1 port0 untouched");
    bus_write(9'h12C, 32'hFFFF);
    bus_read(9'h12C, 32'hFFFF, "R1 port6 mode");
    chk("R2 port6 open-source low data", 64'(pad_oe[55:48]), 64'(0));

    // R2 drive modes
    bus_write(9'h03C, 32'h1EE4);
    chk("R2 oe data A5", 64'(pad_oe[15:8]), 64'(oe_model(16'h1EE4, 8'hA5)));
    chk("R2 pad_out", 64'(pad_out[15:8]), 64'(8'hA5));
    bus_write(9'h038, 32'h5A);
    chk("R2 oe data 5A", 64'(pad_oe[15:8]), 64'(oe_model(16'h1EE4, 8'h5A)));

    // R3 pull-ups
    bus_write(9'h0A0, 32'h0F);
    chk("R3 pull-up port3", 64'(pad_pu[31:24]), 64'(8'hF0));
    chk("R3 other ports", 64'(pad_pu[23:0]), 64'(24'hFFFFFF));

    // R4 synchronized input
    @(negedge clk);
    pad_in[23:16] = 8'h3C;
    exp_q.push_back(32'h00); tag_q.push_back("R4 sync hides same-cycle change");
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 9'h064;
    @(negedge clk);
    bus_sel = 1'b0;
    repeat (3) @(negedge clk);
    bus_read(9'h064, 32'h3C, "R4 sync settled");

    // R5 edges
    bus_write(9'h080, 32'h0F);
    bus_write(9'h074, 32'hFF);
    bus_read(9'h074, 32'h00, "R7 clear all");
    @(negedge clk);
    pad_in[23:16] = 8'hC3;
    repeat (4) @(negedge clk);
    bus_read(9'h074, 32'h33, "R5 polarity per pin");

    // R8 interrupt
    bus_write(9'h078, 32'h01);
    @(negedge clk);
    chk("R8 irq enabled event", 64'(irq[2]), 64'(1));
    bus_write(9'h078, 32'h00);
    @(negedge clk);
    chk("R8 irq disabled", 64'(irq[2]), 64'(0));
    bus_write(9'h074, 32'hFF);
    bus_write(9'h078, 32'hFF);
    @(negedge clk);
    chk("R8 no event no irq", 64'(irq[2]), 64'(0));

    // R6 force, R8 latency
    bus_write(9'h07C, 32'h80);
    chk("R8 irq not yet", 64'(irq[2]), 64'(0));
    @(negedge clk);
    chk("R8 irq one cycle later", 64'(irq[2]), 64'(1));
    bus_write(9'h07C, 32'h00);
    bus_read(9'h074, 32'h80, "R6 force zero no effect");
    bus_write(9'h074, 32'h80);
    bus_read(9'h074, 32'h00, "R7 clear forced");
    chk("R8 irq drops", 64'(irq[2]), 64'(0));

    // R7 set wins, with synchronization off
    bus_write(9'h000, 32'h0);
    bus_write(9'h020, 32'h08);
    bus_write(9'h01C, 32'h08);
    @(negedge clk);
    pad_in[3] = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 9'h014; bus_wdata = 32'h08;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    bus_read(9'h014, 32'h08, "R7 edge beats clear");
    bus_write(9'h014, 32'h08);
    bus_read(9'h014, 32'h00, "R7 clear without edge");

    // R9 raw input path
    @(negedge clk);
    pad_in[7:0] = 8'h81;
    exp_q.push_back(32'h81); tag_q.push_back("R9 raw read sees change");
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 9'h004;
    @(negedge clk);
    bus_sel = 1'b0;
    bus_write(9'h000, 32'h3);
    chk("R9 clk_req", 64'(clk_req), 64'(1));
    bus_read(9'h000, 32'h3, "R9 control readback");

    // R12 out-of-range and unmapped
    snap = pad_out;
    bus_write(9'h158, 32'hFF);
    bus_write(9'h1F8, 32'hFF);
    chk("R12 write ignored", 64'(pad_out), 64'(snap));
    bus_read(9'h158, 32'h0, "R12 port7 reads zero");
    bus_read(9'h1F8, 32'h0, "R12 high index reads zero");
    bus_read(9'h054, 32'h0, "R12 unmapped offset");

    repeat (3) @(negedge clk);
    chk("R13 all reads answered", 64'(exp_q.size()), 64'(0));
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule